// File: doc/BRIEF.md
# Snapshot Frame Packer

The block takes a coherent snapshot of many sensor words on a capture strobe and sends them as one frame of 32-bit words on a valid/ready stream toward a DMA FIFO. The sources form 22 groups. Each group has its own fixed word count. A 22-bit enable word chooses which groups take part. The enabled groups are placed one after another in ascending group index, and the low word of a free-running timestamp always closes the frame. A plain output reports the current frame length.

The enable word is copied into an internal register only while `run` is low and no frame is pending. Otherwise the block ignores it. While `run` is high, a strobe starts a frame unless one of three things holds: `pause` is high, a frame is still pending, or the downstream FIFO reports fewer free words than the frame length. A strobe that is refused while running and not paused adds one to an overflow counter.

Group words pass through unchanged. Their content is fixed by the producers:
- A raw analog word holds the even channel in bits 15:0 and the odd channel in bits 31:16.
- An accumulator group sends its sample count first, then the upper half of the 64-bit sum, then the lower half.
- A count word carries a signed count in bits 31:1.
- A period word carries the period in bits 22:0.

Back-pressure rules: `out_valid` stays high from the first word of a frame to the last. While `out_valid` is high and `out_ready` is low, `out_data` and `out_sof` hold their values. A word moves on each cycle in which both `out_valid` and `out_ready` are high.

Top module: `snap_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `overflow_cnt` is 0 and the stored enable word is 0, so `frame_len` reads 1.
- R2: `frame_len` equals 1 plus the sizes of the enabled groups. The sizes for groups 0 to 21 are 2,2,4,4,2,2,4,4,3,3,2,1,4,4,4,4,4,4,4,4,4,4, and bit g of the enable word enables group g.
- R3: A frame holds the words of the enabled groups in ascending group index, and a disabled group adds no word. Within a group, word w comes from `src_words` bits [(OFF(g)+w)*32 +: 32]. OFF(g) is the sum of the sizes of groups 0 to g-1.
- R4: The last word of every frame is the value of `ts_low` at the capture edge.
- R5: Every word of a frame is the value its source had on the clock edge that accepted the strobe. Later changes to the sources do not affect a frame already captured.
- R6: `cfg_enable` is loaded only on edges where `run` is low and no frame is pending. At all other times it is ignored.
- R7: While `pause` is high, a strobe starts no frame and does not change `overflow_cnt`. The stored enable word is kept.
- R8: While `run` is high and `pause` is low, a strobe is refused and `overflow_cnt` rises by 1 in two cases: a frame is pending (including the cycle of its final transfer), or `fifo_space` is less than `frame_len`.
- R9: `out_sof` is 1 only on the first word of a frame. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sof` hold.
- R10: While `run` is low, a strobe starts no frame and does not change `overflow_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 22 | Group enable word, one bit per group |
| run | input | 1 | Capture enabled; locks the enable word |
| pause | input | 1 | Suppresses new captures |
| cap_strobe | input | 1 | Capture request |
| src_words | input | SRC_WORDS*WORD_W (2336) | All group words, flattened by word index |
| ts_low | input | WORD_W | Low word of the free-running timestamp |
| fifo_space | input | SPACE_W | Free words in the downstream FIFO |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream word accepted |
| out_data | output | WORD_W | Stream word |
| out_sof | output | 1 | First word of a frame |
| frame_len | output | IDX_W (7) | Words per frame for the stored enable word |
| overflow_cnt | output | OVF_W | Count of refused strobes |

## Verification
The frame order is tried with three enable patterns:
- All groups enabled, which exercises every offset up to the 74-word maximum.
- A sparse mix, which shows that disabled groups are skipped and that the remaining groups keep ascending order.
- No groups enabled, which gives a frame made only of the timestamp.

The sources change value on every cycle, so a word captured late or from the wrong index differs from the expected value. Back-pressure is applied as random patterns on `out_ready`. The refusal paths are each provoked on their own: a strobe during a pending frame, a strobe with too little FIFO space, a strobe while paused and a strobe while stopped. This separates the refusals that are counted from those that are ignored. A long random phase then mixes all of these with changes to the enable word while running.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int NGRP = 22;
  // group sizes, group 0 in the least significant field
  localparam logic [NGRP*3-1:0] GRP_SIZES = {
    3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd1,
    3'd2, 3'd3, 3'd3, 3'd4, 3'd4, 3'd2, 3'd2, 3'd4, 3'd4, 3'd2, 3'd2};
  localparam int MAX_GRP_WORDS = 4;

  function automatic int grp_size(input int g);
    return int'(GRP_SIZES[g*3 +: 3]);
  endfunction

  function automatic int grp_off(input int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += grp_size(i);
    return s;
  endfunction

  localparam int SRC_WORDS = grp_off(NGRP);
  localparam int FRAME_MAX = SRC_WORDS + 1;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);
endpackage

// File: rtl/snap_cfg_lock.sv
module snap_cfg_lock import snap_pkg::*; (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run,
  input  logic                               busy,
  input  logic [NGRP-1:0]                    cfg_in,
  output logic [IDX_W-1:0]                   frame_len,
  output logic [FRAME_MAX-1:0][IDX_W-1:0]    word_map
);
  logic [NGRP-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cfg_q <= '0;
    else if (!run && !busy) cfg_q <= cfg_in;
  end

  always_comb begin
    int acc;
    acc = 1;
    for (int g = 0; g < NGRP; g++)
      if (cfg_q[g]) acc += grp_size(g);
    frame_len = IDX_W'(acc);
  end

  // frame position -> snapshot index; unused tail points at the timestamp
  always_comb begin
    int pos;
    pos = 0;
    for (int i = 0; i < FRAME_MAX; i++) word_map[i] = IDX_W'(SRC_WORDS);
    for (int g = 0; g < NGRP; g++)
      for (int w = 0; w < MAX_GRP_WORDS; w++)
        if (cfg_q[g] && w < grp_size(g)) begin
          word_map[pos] = IDX_W'(grp_off(g) + w);
          pos++;
        end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run || busy) |=> $stable(cfg_q)); // R6
endmodule

// File: rtl/snap_latch.sv
module snap_latch import snap_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        load,
  input  logic [SRC_WORDS*WORD_W-1:0] src_words,
  input  logic [WORD_W-1:0]           ts_low,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WORD_W-1:0]           rd_word
);
  logic [WORD_W-1:0] snap [FRAME_MAX];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < SRC_WORDS; i++) snap[i] <= src_words[i*WORD_W +: WORD_W];
      snap[SRC_WORDS] <= ts_low;
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(rd_idx) < FRAME_MAX) rd_word = snap[rd_idx];
  end
endmodule

// File: rtl/snap_emitter.sv
module snap_emitter import snap_pkg::*; #(
  parameter int SPACE_W = 16,
  parameter int OVF_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               run,
  input  logic               pause,
  input  logic [IDX_W-1:0]   frame_len,
  input  logic [SPACE_W-1:0] fifo_space,
  input  logic               out_ready,
  output logic               busy,
  output logic               load,
  output logic [IDX_W-1:0]   pos,
  output logic               sof,
  output logic [OVF_W-1:0]   ovf_cnt
);
  logic want, fits, last;

  assign want = strobe && run && !pause;
  assign fits = 32'(fifo_space) >= 32'(frame_len);
  assign load = want && !busy && fits;
  assign last = busy && (pos == frame_len - IDX_W'(1));
  assign sof  = busy && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pos     <= '0;
      ovf_cnt <= '0;
    end else begin
      if (load) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (busy && out_ready) begin
        if (last) busy <= 1'b0;
        else      pos  <= pos + IDX_W'(1);
      end
      if (want && !load) ovf_cnt <= ovf_cnt + OVF_W'(1);
    end
  end

  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_cnt == $past(ovf_cnt)) || (ovf_cnt == $past(ovf_cnt) + OVF_W'(1))); // R8
  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pos < frame_len)); // R3
endmodule

// File: rtl/snap_packer.sv
module snap_packer import snap_pkg::*; #(
  parameter int WORD_W  = 32,
  parameter int SPACE_W = 16,
  parameter int OVF_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGRP-1:0]             cfg_enable,
  input  logic                        run,
  input  logic                        pause,
  input  logic                        cap_strobe,
  input  logic [SRC_WORDS*WORD_W-1:0] src_words,
  input  logic [WORD_W-1:0]           ts_low,
  input  logic [SPACE_W-1:0]          fifo_space,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WORD_W-1:0]           out_data,
  output logic                        out_sof,
  output logic [IDX_W-1:0]            frame_len,
  output logic [OVF_W-1:0]            overflow_cnt
);
  logic                            busy, load;
  logic [IDX_W-1:0]                pos;
  logic [FRAME_MAX-1:0][IDX_W-1:0] word_map;

  snap_cfg_lock u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .cfg_in(cfg_enable),
    .frame_len(frame_len), .word_map(word_map));

  snap_emitter #(.SPACE_W(SPACE_W), .OVF_W(OVF_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .run(run), .pause(pause),
    .frame_len(frame_len), .fifo_space(fifo_space), .out_ready(out_ready),
    .busy(busy), .load(load), .pos(pos), .sof(out_sof), .ovf_cnt(overflow_cnt));

  snap_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .load(load), .src_words(src_words), .ts_low(ts_low),
    .rd_idx(word_map[pos]), .rd_word(out_data));

  assign out_valid = busy;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)); // R9
  AST_PAUSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    pause |=> !$rose(out_valid)); // R7
  AST_STOPPED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !out_valid |=> !out_valid); // R10
endmodule

// File: tb/snap_packer_tb_top.sv
`timescale 1ns/100ps
module snap_packer_tb_top;
  localparam int NG = 22;
  localparam int NW = 73;
  localparam int SZ [NG] = '{2,2,4,4,2,2,4,4,3,3,2,1,4,4,4,4,4,4,4,4,4,4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NG-1:0] cfg_enable = '0;
  logic run = 0, pause = 0, cap_strobe = 0, out_ready = 1;
  logic [NW*32-1:0] src_words = '0;
  logic [31:0] ts_low = '0;
  logic [15:0] fifo_space = 16'd200;
  logic out_valid, out_sof;
  logic [31:0] out_data;
  logic [6:0] frame_len;
  logic [15:0] overflow_cnt;

  always #2.5 clk = ~clk;

  snap_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .run(run), .pause(pause),
    .cap_strobe(cap_strobe), .src_words(src_words), .ts_low(ts_low),
    .fifo_space(fifo_space), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .frame_len(frame_len),
    .overflow_cnt(overflow_cnt));

  int checks = 0, errors = 0;
  logic [NG-1:0] m_cfg = '0;
  logic [15:0] m_ovf = '0;
  logic [31:0] eq[$];
  bit sq[$];
  string tq[$];

  function automatic int ref_len(input logic [NG-1:0] c);
    int n;
    n = 1;
    for (int g = 0; g < NG; g++) if (c[g]) n += SZ[g];
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit want, idle, acc;
    int off;
    logic [NG-1:0] ncfg;
    want = cap_strobe && run && !pause;
    idle = (eq.size() == 0);
    acc  = want && idle && (int'(fifo_space) >= ref_len(m_cfg));
    ncfg = m_cfg;
    if (!run && idle) ncfg = cfg_enable;
    if (!idle && out_ready) begin
      void'(eq.pop_front()); void'(sq.pop_front()); void'(tq.pop_front());
    end
    if (acc) begin
      off = 0;
      for (int g = 0; g < NG; g++) begin
        if (m_cfg[g])
          for (int w = 0; w < SZ[g]; w++) begin
            eq.push_back(src_words[(off+w)*32 +: 32]);
            sq.push_back(eq.size() == 1);
            tq.push_back("R3 R5 group word");
          end
        off += SZ[g];
      end
      eq.push_back(ts_low);
      sq.push_back(eq.size() == 1);
      tq.push_back("R4 timestamp word");
    end
    if (want && !acc) m_ovf++;
    m_cfg = ncfg;
  endtask

  task automatic compare();
    chk(out_valid === (eq.size() > 0), "R9 valid", 32'(out_valid), 32'(eq.size() > 0));
    if (eq.size() > 0) begin
      chk(out_data === eq[0], tq[0], out_data, eq[0]);
      chk(out_sof === sq[0], "R9 sof", 32'(out_sof), 32'(sq[0]));
    end
    chk(32'(frame_len) === 32'(ref_len(m_cfg)), "R2 R6 frame length", 32'(frame_len), 32'(ref_len(m_cfg)));
    chk(overflow_cnt === m_ovf, "R7 R8 R10 overflow count", 32'(overflow_cnt), 32'(m_ovf));
  endtask

  task automatic tick();
    for (int i = 0; i < NW; i++) src_words[i*32 +: 32] = $urandom;
    ts_low = ts_low + 32'd3;
    model_step();
    @(posedge clk); #1;
    compare();
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input int strobe_pct, input int ready_pct);
    for (int i = 0; i < n; i++) begin
      cap_strobe = ($urandom_range(99) < strobe_pct);
      out_ready  = ($urandom_range(99) < ready_pct);
      tick();
    end
    cap_strobe = 0;
    out_ready  = 1;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.1;
    chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 0);
    chk(overflow_cnt === 16'd0, "R1 reset overflow", 32'(overflow_cnt), 0);
    chk(frame_len === 7'd1, "R1 reset length", 32'(frame_len), 1);

    // all groups, maximum frame; enable changes while running are ignored (R6)
    cfg_enable = '1; tick(); tick();
    run = 1; cfg_enable = '0;
    cap_strobe = 1; tick(); cap_strobe = 0;
    ticks(5, 0, 100);
    cap_strobe = 1; tick(); cap_strobe = 0;   // dropped while pending (R8)
    ticks(100, 0, 60);

    // sparse mix with back-pressure
    run = 0; cfg_enable = 22'h15A9C3; tick();
    run = 1; cfg_enable = 22'h2AAAAA;
    ticks(80, 12, 50);
    ticks(40, 0, 100);

    // pause: strobes ignored and not counted (R7)
    pause = 1; ticks(10, 100, 100); pause = 0;
    // too little room (R8)
    fifo_space = 16'd3; ticks(5, 100, 100); fifo_space = 16'd200;
    ticks(40, 0, 100);
    // stopped: strobes ignored (R10)
    run = 0; cfg_enable = '0; ticks(6, 100, 100);
    // timestamp-only frames (R4)
    run = 1; ticks(20, 50, 70);
    ticks(10, 0, 100);

    // random mix
    for (int r = 0; r < 30; r++) begin
      run = 0; cfg_enable = NG'($urandom);
      ticks(3, 30, 100);
      run = 1; cfg_enable = NG'($urandom);
      pause = ($urandom_range(3) == 0);
      fifo_space = 16'($urandom_range(90));
      ticks(60, 10, 65);
      pause = 0;
      ticks(80, 0, 100);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule